// File: doc/BRIEF.md
# Asynchronous External Memory Read Sequencer

This block runs single read accesses on an external memory bus that has no clock of its own. Internally, a client presents an address with a request strobe whenever the ready output is high. The block then runs the external access and returns the read word with a one-clock data-valid pulse. Externally, it drives an address bus, an active-low chip select, an active-low read strobe and a write strobe that stays high. It samples a data bus and a ready/acknowledge line that the memory uses to ask for more time.

Every external phase lasts a whole number of clock periods. One clock of address and select precedes the strobe. The strobe stays low for a programmable number of wait states. After the strobe rises, address and select are held for a programmable number of read-hold cycles. A programmable number of idle cycles follows before the next access may begin. The three counts are sampled when a request is accepted. The acknowledge line passes through a two-flop synchronizer. It is only consulted once the programmed wait states have run out, so a slow device can stretch the strobe.

Top module: `amem_rd_seq`

## Requirements
- R1: When a request is accepted, the select goes low and the request address appears on the address bus at that clock edge. The read strobe falls exactly one clock later.
- R2: With acknowledge high, the read strobe stays low for exactly the programmed wait count of clock periods.
- R3: A programmed wait count of zero gives a strobe that is low for exactly one clock period.
- R4: When acknowledge is low, the strobe is held low past the wait count. If acknowledge is raised during the k-th low cycle of the strobe, and k is at least the wait count, the strobe is low for exactly k+2 cycles (two synchronizer flops plus the ending edge).
- R5: After the strobe rises, the select stays low for exactly the programmed read-hold count of clocks. The address does not change while the select is low.
- R6: Ready is low from the accepting edge until hold+idle clocks after the strobe rises. With a request waiting, the strobe is high for exactly hold+idle+2 clocks between two accesses.
- R7: The read word is the data bus value sampled at the clock edge where the strobe rises. Changes on the data bus after that edge do not alter it.
- R8: Data-valid is high for exactly one clock, the clock that begins at the edge where the strobe rises.
- R9: The write strobe is high at all times.
- R10: A request presented while ready is low is ignored and starts no access.
- R11: After reset, ready is high, select and both strobes are high, and data-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request, taken when rdy is high |
| req_addr | input | ADDR_W | Read address |
| cfg_wait | input | CNT_W | Wait-state count (0 acts as 1) |
| cfg_hold | input | CNT_W | Read-hold count after strobe rise |
| cfg_idle | input | CNT_W | Idle count after the hold cycles |
| rdy | output | 1 | Block can accept a request |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-clock pulse: rd_data is new |
| mem_addr | output | ADDR_W | External address bus |
| mem_sel_n | output | 1 | External select, active low |
| mem_rd_n | output | 1 | External read strobe, active low |
| mem_wr_n | output | 1 | External write strobe, held high |
| mem_data_in | input | DATA_W | External data bus |
| mem_ack | input | 1 | External acknowledge, low stretches the strobe |

## Verification
The bench builds the block with a 12-bit address, an 8-bit data word and a 3-bit count width. Every count value from zero up to the field maximum of seven therefore stays a few clocks long. This puts zero-wait, zero-hold and zero-idle corners within reach alongside the largest settings. It also makes acknowledge stretches that outlast the wait count short enough to measure cycle by cycle, and back-to-back gaps for both the minimal and a long hold-plus-idle setting.

// File: rtl/amem_pkg.sv
// Package: shared state encoding for the external read sequencer.
// Assumes: nothing; types only.
package amem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_GAP    = 3'd4
    } amem_state_t;
endpackage

// File: rtl/amem_ack_sync.sv
// Module: multi-flop synchronizer for the external acknowledge line.
// Assumes: STAGES >= 2; the input is asynchronous to clk.
module amem_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_out
);
    logic [STAGES-1:0] shreg;

    // Shift the raw acknowledge through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], ack_in};
    end

    assign ack_out = shreg[STAGES-1];
endmodule

// File: rtl/amem_cnt.sv
// Module: loadable phase down-counter. last is high when one cycle remains.
// Assumes: the loaded value is nonzero for phases that use it.
module amem_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Load a phase length, or count down and saturate at one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= ld_val;
        else if (dec && (cnt > CNT_W'(1)))
            cnt <= cnt - CNT_W'(1);
    end

    assign last = (cnt <= CNT_W'(1));
endmodule

// File: rtl/amem_rd_fsm.sv
// Module: phase sequencer (setup, strobe, hold, gap) for one read access.
// Assumes: wait_eff is nonzero; hold/idle counts are latched by the parent.
module amem_rd_fsm
    import amem_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_fire,
    input  logic             cnt_last,
    input  logic             ack_ok,
    input  logic [CNT_W-1:0] wait_eff,
    input  logic [CNT_W-1:0] hold_cnt,
    input  logic [CNT_W-1:0] idle_cnt,
    output amem_state_t      state_q,
    output amem_state_t      state_d,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_ld_val,
    output logic             cnt_dec
);
    logic hold_zero;
    logic idle_zero;

    assign hold_zero = (hold_cnt == '0);
    assign idle_zero = (idle_cnt == '0);

    // Choose the next phase and the counter load for it.
    always_comb begin
        state_d    = state_q;
        cnt_load   = 1'b0;
        cnt_ld_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                state_d    = ST_STROBE;
                cnt_load   = 1'b1;
                cnt_ld_val = wait_eff;
            end
            ST_STROBE: begin
                if (cnt_last && ack_ok) begin
                    if (!hold_zero) begin
                        state_d    = ST_HOLD;
                        cnt_load   = 1'b1;
                        cnt_ld_val = hold_cnt;
                    end else if (!idle_zero) begin
                        state_d    = ST_GAP;
                        cnt_load   = 1'b1;
                        cnt_ld_val = idle_cnt;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_last) begin
                    if (!idle_zero) begin
                        state_d    = ST_GAP;
                        cnt_load   = 1'b1;
                        cnt_ld_val = idle_cnt;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (cnt_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Count down only inside the timed phases.
    assign cnt_dec = (state_q == ST_STROBE) || (state_q == ST_HOLD) || (state_q == ST_GAP);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/amem_rd_seq.sv
// Module: top of the external read sequencer. Registers every external pin,
// latches request address and counts, captures data at the strobe's rise.
// Assumes: mem_data_in is stable around the rising strobe edge; mem_ack async.
module amem_rd_seq
    import amem_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 4,
    parameter int ACK_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic [CNT_W-1:0]  cfg_idle,
    output logic              rdy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    input  logic [DATA_W-1:0] mem_data_in,
    input  logic              mem_ack
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    amem_state_t      state_q;
    amem_state_t      state_d;
    logic             req_fire;
    logic             ack_s;
    logic             cnt_last;
    logic             cnt_load;
    logic             cnt_dec;
    logic [CNT_W-1:0] cnt_ld_val;
    logic [CNT_W-1:0] wait_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] idle_q;
    logic             capture;

    assign req_fire = req_valid && rdy;
    assign mem_wr_n = 1'b1;

    amem_ack_sync #(.STAGES(ACK_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_in  (mem_ack),
        .ack_out (ack_s)
    );

    amem_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .ld_val (cnt_ld_val),
        .dec    (cnt_dec),
        .last   (cnt_last)
    );

    amem_rd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .cnt_last   (cnt_last),
        .ack_ok     (ack_s),
        .wait_eff   (wait_q),
        .hold_cnt   (hold_q),
        .idle_cnt   (idle_q),
        .state_q    (state_q),
        .state_d    (state_d),
        .cnt_load   (cnt_load),
        .cnt_ld_val (cnt_ld_val),
        .cnt_dec    (cnt_dec)
    );

    // Latch address and phase counts when a request is taken; zero wait acts as one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wait_q   <= ONE;
            hold_q   <= '0;
            idle_q   <= '0;
        end else if (req_fire) begin
            mem_addr <= req_addr;
            wait_q   <= (cfg_wait == '0) ? ONE : cfg_wait;
            hold_q   <= cfg_hold;
            idle_q   <= cfg_idle;
        end
    end

    // Register the pins from the next phase so they change on clock edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_rd_n  <= 1'b1;
            rdy       <= 1'b1;
        end else begin
            mem_sel_n <= !((state_d == ST_SETUP) || (state_d == ST_STROBE) || (state_d == ST_HOLD));
            mem_rd_n  <= !(state_d == ST_STROBE);
            rdy       <= (state_d == ST_IDLE);
        end
    end

    assign capture = (state_q == ST_STROBE) && (state_d != ST_STROBE);

    // Sample the data bus at the strobe's rising edge and flag it for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_data_in;
        end
    end
endmodule

// File: rtl/amem_rd_chk.sv
// Module: protocol checker for the external read sequencer, bound to the top.
// Assumes: observes ports only.
module amem_rd_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rdy,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_rd_n
);
    AST_SEL_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> !$past(mem_sel_n)); // R1
    AST_STROBE_INSIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_sel_n); // R1
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr)); // R5
    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R8
    AST_VALID_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(mem_rd_n)); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (mem_sel_n && mem_rd_n)); // R6
    AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_sel_n) |-> ($past(rdy) && $past(req_valid))); // R10
endmodule

bind amem_rd_seq amem_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rdy       (rdy),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_rd_n  (mem_rd_n)
);

// File: tb/tb_amem_rd_seq.sv
module tb_amem_rd_seq;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] cfg_wait = '0;
    logic [CW-1:0] cfg_hold = '0;
    logic [CW-1:0] cfg_idle = '0;
    logic          rdy;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n;
    logic          mem_rd_n;
    logic          mem_wr_n;
    logic [DW-1:0] mem_data_in = '0;
    logic          mem_ack = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    amem_rd_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .ACK_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_idle(cfg_idle),
        .rdy(rdy), .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_data_in(mem_data_in), .mem_ack(mem_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_rdy();
        while (rdy !== 1'b1) @(negedge clk);
    endtask

    // R11: state straight after reset.
    task automatic t_reset();
        chk("R11 rdy", 32'(rdy), 32'd1);
        chk("R11 sel_n", 32'(mem_sel_n), 32'd1);
        chk("R11 rd_n", 32'(mem_rd_n), 32'd1);
        chk("R11 rd_valid", 32'(rd_valid), 32'd0);
        chk("R9 wr_n", 32'(mem_wr_n), 32'd1);
    endtask

    // One read: R1 setup, R2/R3/R4 strobe length, R5 hold, R6 busy time, R7 data, R8 pulse, R9.
    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int w, input int h, input int i, input int ack_after);
        int low = 0;
        int hold = 0;
        int busy = 0;
        int vc = 0;
        int exp_low;
        bit sel_bad = 0;
        bit wr_bad = 0;
        bit addr_bad = 0;
        exp_low = (ack_after != 0) ? ack_after + 2 : ((w == 0) ? 1 : w);
        @(negedge clk);
        wait_rdy();
        cfg_wait = CW'(w); cfg_hold = CW'(h); cfg_idle = CW'(i);
        mem_ack = (ack_after == 0);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        cfg_wait = '1; cfg_hold = '1; cfg_idle = '1;
        chk("R1 sel low in setup", 32'(mem_sel_n), 32'd0);
        chk("R1 strobe high in setup", 32'(mem_rd_n), 32'd1);
        chk("R1 address", 32'(mem_addr), 32'(a));
        chk("R6 rdy low after accept", 32'(rdy), 32'd0);
        @(negedge clk);
        while (mem_rd_n == 1'b0 && low < 40) begin
            low++;
            mem_data_in = d;
            if (mem_sel_n !== 1'b0) sel_bad = 1;
            if (mem_wr_n !== 1'b1) wr_bad = 1;
            if (ack_after != 0 && low == ack_after) mem_ack = 1'b1;
            @(negedge clk);
        end
        mem_data_in = ~d;
        chk(ack_after != 0 ? "R4 stretched strobe" : (w == 0 ? "R3 zero wait" : "R2 strobe length"),
            32'(low), 32'(exp_low));
        chk("R1 select low under strobe", 32'(sel_bad), 32'd0);
        chk("R7 captured data", 32'(rd_data), 32'(d));
        chk("R8 valid at rise", 32'(rd_valid), 32'd1);
        while (busy < 40) begin
            if (mem_sel_n == 1'b0) begin
                hold++;
                if (mem_addr !== a) addr_bad = 1;
            end
            if (mem_wr_n !== 1'b1) wr_bad = 1;
            if (rd_valid) vc++;
            if (rdy) break;
            busy++;
            @(negedge clk);
        end
        chk("R5 hold cycles", 32'(hold), 32'(h));
        chk("R5 address held", 32'(addr_bad), 32'd0);
        chk("R6 busy after strobe", 32'(busy), 32'(h + i));
        chk("R8 single pulse", 32'(vc), 32'd1);
        @(negedge clk);
        chk("R8 pulse ended", 32'(rd_valid), 32'd0);
        chk("R7 data kept", 32'(rd_data), 32'(d));
        chk("R9 wr_n high", 32'(wr_bad), 32'd0);
        mem_ack = 1'b1;
    endtask

    // R6: strobe-high gap between two accesses with a request waiting.
    task automatic t_back2back(input int h, input int i);
        int gap = 0;
        @(negedge clk);
        wait_rdy();
        cfg_wait = CW'(2); cfg_hold = CW'(h); cfg_idle = CW'(i);
        mem_ack = 1'b1;
        req_valid = 1'b1; req_addr = 12'h111;
        while (mem_rd_n == 1'b1) @(negedge clk);
        while (mem_rd_n == 1'b0) @(negedge clk);
        while (mem_rd_n == 1'b1 && gap < 40) begin
            gap++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R6 back-to-back gap", 32'(gap), 32'(h + i + 2));
        wait_rdy();
    endtask

    // R10: a request while busy must not start another access.
    task automatic t_ignore();
        bit started = 0;
        @(negedge clk);
        wait_rdy();
        cfg_wait = CW'(3); cfg_hold = CW'(1); cfg_idle = CW'(1);
        req_valid = 1'b1; req_addr = 12'h2C0;
        @(negedge clk);
        req_addr = 12'hABC;
        @(negedge clk);
        req_valid = 1'b0;
        wait_rdy();
        repeat (4) begin
            if (mem_sel_n !== 1'b1) started = 1;
            @(negedge clk);
        end
        chk("R10 no extra access", 32'(started), 32'd0);
        chk("R10 address unchanged", 32'(mem_addr), 32'h2C0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read(12'h3A5, 8'h5C, 3, 2, 1, 0);
        t_read(12'h001, 8'hA3, 0, 0, 0, 0);
        t_read(12'hFFE, 8'h0F, 7, 0, 3, 0);
        t_read(12'h7C2, 8'hE1, 1, 7, 0, 0);
        t_read(12'h456, 8'h99, 2, 1, 1, 4);
        t_read(12'h0A0, 8'h3C, 1, 0, 2, 1);
        t_back2back(0, 0);
        t_back2back(2, 3);
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule